// File: doc/BRIEF.md
# Peripheral Interrupt Routing Controller

This block sits between a set of peripheral interrupt request lines and the general-purpose priority levels 7 to 15 of a core event controller. Every source has four settings: a forwarding mask bit, a raw status bit, a wake-up enable bit and a level assignment field. All unmasked sources that share a level are merged into one request line for that level. The assignment fields can be rewritten at run time, including while other sources share the same level.

The core's per-level pending bits come back into the router as the acknowledgement that a level's event has entered service. While a level is pending, its request line is held low. When the pending bit clears and a source on that level is still asserting, the request rises again, so the core sees a new rising edge.

A wake-up output is raised whenever a source with its wake-up enable set is asserting, whatever its mask bit holds. Software reaches the mask, status, wake-up and assignment registers through a simple word-addressed write port with a combinational read port.

Top module: `irq_router`

## Requirements
- R1: After reset the mask and wake-up enable registers read 0, the level requests and wake-up output are 0, and source n is assigned field value n mod 9, i.e. level 7 + (n mod 9).
- R2: Address 0 is the mask register; bit n = 1 forwards source n, and bit n = 0 keeps source n out of every level request.
- R3: Address 1 is the status register; bit n reads the source n input as sampled at the last clock edge, independent of the mask, and writes to it are ignored.
- R4: Address 2 is the wake-up enable register; wake_req is the OR over all sources of (sampled source AND enable bit), independent of the mask register.
- R5: Addresses 3 to 6 hold the assignment fields, 4 bits per source; source n sits at address 3 + n/8, bits [4*(n mod 8)+3 : 4*(n mod 8)]. Field value v from 0 to 8 selects level 7 + v (lvl_req bit v), and values 9 to 15 leave the source unassigned.
- R6: lvl_req bit v is the OR of every unmasked, asserting source whose field holds v, so simultaneous sources on one level merge into one request.
- R7: While lvl_pend bit v is 1, lvl_req bit v is 0 on the next cycle. After the pending bit clears, the request reasserts if a source on that level is still asserting.
- R8: A change on src_irq reaches lvl_req and wake_req after two rising clock edges. A change on lvl_pend reaches lvl_req after one edge. A register write takes effect one edge after it is captured.
- R9: Rewriting the assignment field of one source at run time moves only that source to its new level; other sources that shared its old level keep that level requested.
- R10: Writes to addresses 7 to 15 change no register, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | 32 | Peripheral interrupt request lines, active high |
| lvl_pend | input | 9 | Core pending bits for levels 7..15 (bit 0 = level 7) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational from registers) |
| lvl_req | output | 9 | Merged request per level (bit 0 = level 7) |
| wake_req | output | 1 | Wake-up request |

## Verification
A source edge must show on lvl_req and wake_req after the second rising edge: one edge for the sampling register and one for the output register. A pending bit acts on its level after a single edge, and a write is captured at one edge and acts on the requests one edge after that. The bench holds a behavioural model that updates on every rising edge from the same inputs. It compares both outputs on every falling edge, so each result is read in the cycle it falls due. Named checks add samples one and two edges after a source change, to pin down that two-edge latency exactly.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    // word addresses of the register port
    localparam int A_MASK  = 0;
    localparam int A_STAT  = 1;
    localparam int A_WAKE  = 2;
    localparam int A_ASGN0 = 3;

    // reset assignment: source n goes to level offset n mod nlvl
    function automatic int default_field(input int n, input int nlvl);
        return n % nlvl;
    endfunction
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_LVL = 9,
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NUM_SRC-1:0]         src_seen,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_SRC-1:0]         mask,
    output logic [NUM_SRC-1:0]         wake_en,
    output logic [NUM_SRC*FIELD_W-1:0] asgn
);
    localparam int FPR = DATA_W / FIELD_W;
    localparam int NUM_ASGN = (NUM_SRC + FPR - 1) / FPR;

    typedef struct packed {
        logic [NUM_SRC-1:0]         mask;
        logic [NUM_SRC-1:0]         wake;
        logic [NUM_SRC*FIELD_W-1:0] asgn;
    } regs_t;

    regs_t st_d, st_q, st_rst;

    always_comb begin
        st_rst = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            st_rst.asgn[n*FIELD_W +: FIELD_W] = FIELD_W'(default_field(n, NUM_LVL));
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (int'(addr) == A_MASK) st_d.mask = wdata[NUM_SRC-1:0];
            if (int'(addr) == A_WAKE) st_d.wake = wdata[NUM_SRC-1:0];
            for (int n = 0; n < NUM_SRC; n++) begin
                if (int'(addr) == A_ASGN0 + n / FPR) begin
                    st_d.asgn[n*FIELD_W +: FIELD_W] = wdata[(n % FPR)*FIELD_W +: FIELD_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (int'(addr) == A_MASK) rdata = DATA_W'(st_q.mask);
        if (int'(addr) == A_STAT) rdata = DATA_W'(src_seen);
        if (int'(addr) == A_WAKE) rdata = DATA_W'(st_q.wake);
        for (int r = 0; r < NUM_ASGN; r++) begin
            if (int'(addr) == A_ASGN0 + r) begin
                for (int k = 0; k < FPR; k++) begin
                    if (r * FPR + k < NUM_SRC) begin
                        rdata[k*FIELD_W +: FIELD_W] = st_q.asgn[(r*FPR + k)*FIELD_W +: FIELD_W];
                    end
                end
            end
        end
    end

    assign mask    = st_q.mask;
    assign wake_en = st_q.wake;
    assign asgn    = st_q.asgn;

    // a mask write is seen on the mask outputs one edge later
    assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == A_MASK) |=> (mask == $past(wdata[NUM_SRC-1:0])));

    // a status write leaves every register untouched
    assert_status_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == A_STAT) |=> $stable(st_q));
endmodule

// File: rtl/irq_router_merge.sv
module irq_router_merge #(
    parameter int NUM_SRC = 32,
    parameter int NUM_LVL = 9,
    parameter int FIELD_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src,
    input  logic [NUM_SRC-1:0]         mask,
    input  logic [NUM_SRC*FIELD_W-1:0] asgn,
    input  logic [NUM_LVL-1:0]         pend,
    output logic [NUM_LVL-1:0]         lvl_req
);
    typedef struct packed {
        logic [NUM_LVL-1:0] req;
    } merge_t;

    merge_t mg_d, mg_q;
    logic [NUM_LVL-1:0] hit;

    always_comb begin
        hit = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            for (int n = 0; n < NUM_SRC; n++) begin
                if (src[n] && mask[n] && (asgn[n*FIELD_W +: FIELD_W] == FIELD_W'(l))) begin
                    hit[l] = 1'b1;
                end
            end
        end
        mg_d.req = hit & ~pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mg_q <= '0;
        else        mg_q <= mg_d;
    end

    assign lvl_req = mg_q.req;

    // with nothing unmasked and asserting, no level is requested next cycle
    assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((src & mask) == '0) |=> (lvl_req == '0));

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl_chk
        assert_pend_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
            pend[l] |=> !lvl_req[l]);
    end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
    parameter int NUM_SRC = 32,
    parameter int NUM_LVL = 9,
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic [NUM_LVL-1:0] lvl_pend,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_LVL-1:0] lvl_req,
    output logic               wake_req
);
    typedef struct packed {
        logic [NUM_SRC-1:0] src;
        logic               wake;
    } edge_t;

    edge_t eg_d, eg_q;
    logic [NUM_SRC-1:0]         mask;
    logic [NUM_SRC-1:0]         wake_en;
    logic [NUM_SRC*FIELD_W-1:0] asgn;

    irq_router_regs #(
        .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .FIELD_W(FIELD_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .src_seen(eg_q.src), .rdata(reg_rdata),
        .mask(mask), .wake_en(wake_en), .asgn(asgn)
    );

    irq_router_merge #(
        .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .FIELD_W(FIELD_W)
    ) merge_i (
        .clk(clk), .rst_n(rst_n), .src(eg_q.src), .mask(mask),
        .asgn(asgn), .pend(lvl_pend), .lvl_req(lvl_req)
    );

    always_comb begin
        eg_d.src  = src_irq;
        eg_d.wake = |(eg_q.src & wake_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eg_q <= '0;
        else        eg_q <= eg_d;
    end

    assign wake_req = eg_q.wake;

    assert_wake_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((eg_q.src & wake_en) == '0) |=> !wake_req);

    // wake-up follows enabled sources even when they are masked
    assert_wake_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((eg_q.src & wake_en) != '0) |=> wake_req);
endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_irq = '0;
    logic [8:0]  lvl_pend = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [8:0]  lvl_req;
    logic        wake_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_router dut_i (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .lvl_pend(lvl_pend),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .lvl_req(lvl_req), .wake_req(wake_req)
    );

    // behavioural reference model
    logic [31:0] m_mask, m_wake, m_srcq;
    int          m_asg [32];
    logic [8:0]  m_req;
    logic        m_wk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = '0; m_wake = '0; m_srcq = '0; m_req = '0; m_wk = 1'b0;
            for (int n = 0; n < 32; n++) m_asg[n] = n % 9;
        end else begin
            logic [8:0] nr;
            nr = '0;
            for (int l = 0; l < 9; l++) begin
                for (int n = 0; n < 32; n++)
                    if (m_srcq[n] && m_mask[n] && m_asg[n] == l) nr[l] = 1'b1;
                if (lvl_pend[l]) nr[l] = 1'b0;
            end
            m_req  = nr;
            m_wk   = |(m_srcq & m_wake);
            m_srcq = src_irq;
            if (reg_wr) begin
                if (reg_addr == 0) m_mask = reg_wdata;
                if (reg_addr == 2) m_wake = reg_wdata;
                if (reg_addr >= 3 && reg_addr <= 6)
                    for (int k = 0; k < 8; k++)
                        m_asg[(int'(reg_addr) - 3) * 8 + k] = int'((reg_wdata >> (4 * k)) & 32'hF);
            end
        end
    end

    function automatic logic [31:0] m_read(input int a);
        logic [31:0] v;
        v = '0;
        if (a == 0) v = m_mask;
        if (a == 1) v = m_srcq;
        if (a == 2) v = m_wake;
        if (a >= 3 && a <= 6)
            for (int k = 0; k < 8; k++) v[4*k +: 4] = 4'(m_asg[(a - 3) * 8 + k]);
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(lvl_req == m_req, "R6 level request vs model", 32'(lvl_req), 32'(m_req));
            chk(wake_req == m_wk, "R4 wake output vs model", 32'(wake_req), 32'(m_wk));
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = 4'(a);
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
        chk(reg_rdata == m_read(a), {tag, " model"}, reg_rdata, m_read(a));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] dflt_reg(input int r);
        logic [31:0] v;
        for (int k = 0; k < 8; k++) v[4*k +: 4] = 4'((r * 8 + k) % 9);
        return v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(lvl_req == 9'd0, "R1 lvl_req after reset", 32'(lvl_req), 0);
        chk(wake_req == 1'b0, "R1 wake_req after reset", 32'(wake_req), 0);
        rd(0, 32'h0, "R1 mask reset");
        rd(2, 32'h0, "R1 wake reset");
        for (int r = 0; r < 4; r++) rd(3 + r, dflt_reg(r), "R1 default assignment");

        // R2 masked sources give no request; R3 status raw
        @(negedge clk); src_irq = 32'h0000_0209;
        idle(3);
        chk(lvl_req == 9'd0, "R2 all masked", 32'(lvl_req), 0);
        rd(1, 32'h0000_0209, "R3 status ignores mask");
        wr(1, 32'hFFFF_FFFF);
        rd(1, 32'h0000_0209, "R3 status write ignored");
        rd(0, 32'h0, "R3 mask after status write");

        // R6 merge: sources 0 and 9 on level offset 0, source 3 on offset 3
        wr(0, 32'hFFFF_FFFF);
        idle(2);
        chk(lvl_req == 9'b0_0000_1001, "R6 merged requests", 32'(lvl_req), 32'h009);
        @(negedge clk); src_irq = 32'h0000_0208;
        idle(3);
        chk(lvl_req == 9'b0_0000_1001, "R6 shared level held by source 9", 32'(lvl_req), 32'h009);
        wr(0, 32'hFFFF_FDFF);
        idle(2);
        chk(lvl_req == 9'b0_0000_1000, "R2 mask clear drops source 9", 32'(lvl_req), 32'h008);
        wr(0, 32'hFFFF_FFFF);
        idle(2);

        // R7 pending drops request, reasserts afterwards
        @(negedge clk); lvl_pend = 9'b0_0000_0001;
        @(negedge clk);
        chk(lvl_req[0] == 1'b0, "R7 pending drops level", 32'(lvl_req[0]), 0);
        chk(lvl_req[3] == 1'b1, "R7 other level unaffected", 32'(lvl_req[3]), 1);
        idle(2);
        lvl_pend = '0;
        @(negedge clk);
        chk(lvl_req[0] == 1'b1, "R7 request reasserts after service", 32'(lvl_req[0]), 1);

        // R4 wake independent of mask
        wr(0, 32'h0);
        wr(2, 32'h0000_0200);
        idle(1);
        chk(wake_req == 1'b1, "R4 wake with source masked", 32'(wake_req), 1);
        chk(lvl_req == 9'd0, "R4 no request while masked", 32'(lvl_req), 0);
        @(negedge clk); src_irq = 32'h0000_0008;
        idle(2);
        chk(wake_req == 1'b0, "R4 wake falls with source", 32'(wake_req), 0);
        wr(2, 32'h0);

        // R9 remap source 9 to offset 5 while source 0 stays on offset 0
        wr(0, 32'hFFFF_FFFF);
        @(negedge clk); src_irq = 32'h0000_0201;
        idle(3);
        chk(lvl_req == 9'b0_0000_0001, "R9 shared level before remap", 32'(lvl_req), 32'h001);
        wr(4, 32'h6543_2158);
        idle(1);
        chk(lvl_req == 9'b0_0010_0001, "R9 remapped source on new level", 32'(lvl_req), 32'h021);
        rd(4, 32'h6543_2158, "R5 assignment readback");
        // R5 out-of-range field leaves source unassigned
        wr(4, 32'h6543_21C8);
        idle(1);
        chk(lvl_req == 9'b0_0000_0001, "R5 field 12 unassigned", 32'(lvl_req), 32'h001);
        @(negedge clk); src_irq = 32'h0000_0200;
        idle(3);
        chk(lvl_req == 9'd0, "R5 unassigned source alone", 32'(lvl_req), 0);

        // R10 unmapped addresses
        wr(12, 32'hFFFF_FFFF);
        rd(12, 32'h0, "R10 unmapped read zero");
        rd(0, 32'hFFFF_FFFF, "R10 mask untouched");
        rd(4, 32'h6543_21C8, "R10 assignment untouched");

        // R8 latency: source 3 on offset 3
        @(negedge clk); src_irq = 32'h0;
        idle(3);
        @(negedge clk); src_irq = 32'h0000_0008;
        @(negedge clk);
        chk(lvl_req[3] == 1'b0, "R8 not after one edge", 32'(lvl_req[3]), 0);
        @(negedge clk);
        chk(lvl_req[3] == 1'b1, "R8 after two edges", 32'(lvl_req[3]), 1);
        lvl_pend = 9'b0_0000_1000;
        @(negedge clk);
        chk(lvl_req[3] == 1'b0, "R8 pending after one edge", 32'(lvl_req[3]), 0);
        lvl_pend = '0;
        idle(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule